// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block is the processor-side register interface of a two-channel serial controller. A small bus with two address bits, separate read and write strobes and a byte-wide data path gives access to one data byte per channel and to a bank of control and status registers. Control registers are reached indirectly. While the register pointer is zero, a control write loads it. The next control access then goes to the selected register, and after that access the pointer falls back to zero. One command code also sets the top pointer bit, so that the upper half of the register space can be reached.

Each channel keeps its own mode registers, time constant bytes and data byte. The channels also share one interrupt vector register and one master interrupt register. Register 0 writes carry command codes, which leave the block as one-cycle pulses per channel. The receive and transmit character-length fields are decoded into bit counts. A change on a channel's carrier-detect input latches an external-status byte and raises a pending flag. These flags are gated by per-channel and master enables to form a registered interrupt output, with a one-cycle pulse whenever that output changes level.

Top module: `sccreg_front`

## Requirements
- R1: `bus_addr[0]` picks the channel (0 = A, 1 = B) and `bus_addr[1]` picks the data byte (1) or the control path (0). A data write stores into that channel's data byte, and a data read returns it. Data accesses never change the register pointer.
- R2: After reset the pointer is 0. A control write while the pointer is 0 loads `bus_wdata[2:0]` into pointer bits 2:0. If `bus_wdata[5:3]` equals 1, the write also sets pointer bit 3. Otherwise pointer bit 3 is cleared.
- R3: Any control read, and any control write while the pointer is not 0, returns the pointer to 0 at the end of that access.
- R4: Register 2 (interrupt vector) and register 9 (master control) exist once. Writing either one through either channel updates the single copy. Reading register 2 through either channel returns the vector.
- R5: Registers 12 and 13 (time constant low and high) are held per channel and read back unchanged. A write through one channel leaves the other channel's copy untouched.
- R6: A register 0 write produces a one-cycle pulse on the selected channel's bit of one output. Code 1 in `bus_wdata[7:6]` pulses `rx_crc_rst`, code 2 pulses `tx_crc_rst` and code 3 pulses `tx_eom_rst`. The pulse appears in the cycle after the write.
- R7: The receive length (register 3 bits 7:6) and the transmit length (register 5 bits 6:5) decode as 00 = 5, 01 = 7, 10 = 6 and 11 = 8 bits. The results appear on `rx_char_bits` and `tx_char_bits`, with channel c at bits [4c+3:4c]. Both decode to 5 after reset.
- R8: Reading register 0 returns the channel's live carrier input in bit 3, with all other bits 0. Reading register 1 returns 0x01.
- R9: A change on a channel's carrier input, when that channel's pending flag is clear, sets the flag. It also latches a status byte with bit 3 equal to the new carrier level. While the flag is set, further changes do not alter the latch. Register 15 returns the latched byte. Register 3 read through channel A returns B's flag in bit 0 and A's flag in bit 3. Through channel B it returns 0.
- R10: A register 0 write with `bus_wdata[5:3]` = 2 clears that channel's pending flag and latched byte. If a carrier change arrives on that channel in the same cycle, the flag ends set and the latch holds the new carrier level.
- R11: `irq` is set one cycle after the state where register 9 bit 3 is set and some channel has both its pending flag and register 1 bit 0 set. `irq_chg` is high for exactly the cycle in which `irq` has just changed level.
- R12: Reset sets the pointer to 0 and clears all pending flags, all enables, `irq` and `irq_chg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Bit 0 channel, bit 1 data/control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| carrier | input | 2 | Carrier-detect level per channel |
| irq | output | 1 | Registered interrupt request |
| irq_chg | output | 1 | One-cycle pulse when `irq` changes |
| rx_char_bits | output | 8 | Decoded receive length, 4 bits per channel |
| tx_char_bits | output | 8 | Decoded transmit length, 4 bits per channel |
| rx_crc_rst | output | 2 | Receive CRC reset command pulse per channel |
| tx_crc_rst | output | 2 | Transmit CRC reset command pulse per channel |
| tx_eom_rst | output | 2 | Transmit underrun latch reset pulse per channel |

## Verification
The external-status clear command and a carrier change on the same channel can land on the same clock edge. In that case one path sets the pending flag and latch while the other clears them. The bench provokes this by driving the carrier edge and the register 0 clear write in the same cycle. It first walks the channel through a clear and a carrier change, so that the latched byte before (0x00) differs from the one expected after (0x08). It then judges the outcome through register 15 and through register 3 read via channel A. Both must show the flag still set and the latch holding the new level.

// File: rtl/sccreg_pkg.sv
package sccreg_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 4;
    localparam int unsigned LEN_W  = 4;
    localparam int unsigned NCH    = 2;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam ptr_t REG_CMD   = 4'd0;
    localparam ptr_t REG_IEN   = 4'd1;
    localparam ptr_t REG_VEC   = 4'd2;
    localparam ptr_t REG_RXM   = 4'd3;
    localparam ptr_t REG_TXM   = 4'd5;
    localparam ptr_t REG_MST   = 4'd9;
    localparam ptr_t REG_TCLO  = 4'd12;
    localparam ptr_t REG_TCHI  = 4'd13;
    localparam ptr_t REG_XSTAT = 4'd15;

    localparam logic [2:0] OP_PTR_HI  = 3'd1;
    localparam logic [2:0] OP_EXT_CLR = 3'd2;

    function automatic logic [LEN_W-1:0] len_decode(input logic [1:0] code);
        case (code)
            2'b00:   len_decode = LEN_W'(5);
            2'b01:   len_decode = LEN_W'(7);
            2'b10:   len_decode = LEN_W'(6);
            default: len_decode = LEN_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/sccreg_ptr.sv
module sccreg_ptr
    import sccreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ctl_wr,
    input  logic  ctl_rd,
    input  byte_t wdata,
    output ptr_t  ptr
);

    typedef struct packed {
        ptr_t sel;
    } ptr_state_t;

    ptr_state_t q, d;

    always_comb begin
        d = q;
        if (ctl_wr) begin
            if (q.sel == REG_CMD) begin
                d.sel = {wdata[5:3] == OP_PTR_HI, wdata[2:0]};
            end else begin
                d.sel = REG_CMD;
            end
        end else if (ctl_rd) begin
            d.sel = REG_CMD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr = q.sel;

    // R3
    ptr_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd && !ctl_wr) |=> (ptr == REG_CMD));

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr == REG_CMD) |=> (ptr[2:0] == $past(wdata[2:0])));

    // R2
    ptr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr == REG_CMD && wdata[5:3] == OP_PTR_HI) |=> ptr[3]);

endmodule

// File: rtl/sccreg_chan.sv
module sccreg_chan
    import sccreg_pkg::*;
#(
    parameter int unsigned EXT_EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             data_wr,
    input  ptr_t             ptr,
    input  byte_t            wdata,
    input  logic             carrier,
    output byte_t            data_byte,
    output byte_t            tc_lo,
    output byte_t            tc_hi,
    output byte_t            xstat,
    output logic             pend,
    output logic             ext_en,
    output logic [LEN_W-1:0] rx_len,
    output logic [LEN_W-1:0] tx_len,
    output logic             rx_crc_pulse,
    output logic             tx_crc_pulse,
    output logic             eom_pulse
);

    typedef struct packed {
        byte_t      data;
        byte_t      ien;
        byte_t      rxm;
        byte_t      txm;
        byte_t      tclo;
        byte_t      tchi;
        byte_t      xmask;
        byte_t      stat;
        logic       pend;
        logic       car;
        logic [2:0] pulse;
    } chan_state_t;

    chan_state_t q, d;
    logic evt;
    logic clr;

    always_comb begin
        d       = q;
        d.pulse = '0;
        d.car   = carrier;
        evt     = (carrier != q.car);
        clr     = 1'b0;
        if (data_wr) d.data = wdata;
        if (ctl_wr) begin
            case (ptr)
                REG_CMD: begin
                    case (wdata[7:6])
                        2'd1:    d.pulse[0] = 1'b1;
                        2'd2:    d.pulse[1] = 1'b1;
                        2'd3:    d.pulse[2] = 1'b1;
                        default: ;
                    endcase
                    clr = (wdata[5:3] == OP_EXT_CLR);
                end
                REG_IEN:   d.ien   = wdata;
                REG_RXM:   d.rxm   = wdata;
                REG_TXM:   d.txm   = wdata;
                REG_TCLO:  d.tclo  = wdata;
                REG_TCHI:  d.tchi  = wdata;
                REG_XSTAT: d.xmask = wdata;
                default: ;
            endcase
        end
        if (clr) begin
            d.pend = 1'b0;
            d.stat = '0;
        end
        if (evt && (!q.pend || clr)) begin
            d.pend = 1'b1;
            d.stat = {4'b0, carrier, 3'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_byte    = q.data;
    assign tc_lo        = q.tclo;
    assign tc_hi        = q.tchi;
    assign xstat        = q.stat;
    assign pend         = q.pend;
    assign ext_en       = q.ien[EXT_EN_BIT];
    assign rx_len       = len_decode(q.rxm[7:6]);
    assign tx_len       = len_decode(q.txm[6:5]);
    assign rx_crc_pulse = q.pulse[0];
    assign tx_crc_pulse = q.pulse[1];
    assign eom_pulse    = q.pulse[2];

    // R6
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_crc_pulse, tx_crc_pulse, eom_pulse}));

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> (pend && $stable(xstat)));

    // R10
    ext_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!pend && xstat == '0));

endmodule

// File: rtl/sccreg_front.sv
module sccreg_front
    import sccreg_pkg::*;
#(
    parameter int unsigned MIE_BIT    = 3,
    parameter int unsigned EXT_EN_BIT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    input  logic [NCH-1:0]       carrier,
    output logic                 irq,
    output logic                 irq_chg,
    output logic [NCH*LEN_W-1:0] rx_char_bits,
    output logic [NCH*LEN_W-1:0] tx_char_bits,
    output logic [NCH-1:0]       rx_crc_rst,
    output logic [NCH-1:0]       tx_crc_rst,
    output logic [NCH-1:0]       tx_eom_rst
);

    typedef struct packed {
        byte_t vec;
        byte_t mst;
        logic  irq;
        logic  chg;
    } shared_state_t;

    shared_state_t q, d;

    logic   ctl_wr, ctl_rd, data_wr;
    logic   ch_sel;
    ptr_t   ptr;
    byte_t  ch_data  [NCH];
    byte_t  ch_tclo  [NCH];
    byte_t  ch_tchi  [NCH];
    byte_t  ch_xstat [NCH];
    logic [NCH-1:0] ch_pend;
    logic [NCH-1:0] ch_ext_en;
    logic   irq_src;

    assign ctl_wr  = bus_wr && !bus_addr[1];
    assign ctl_rd  = bus_rd && !bus_addr[1];
    assign data_wr = bus_wr && bus_addr[1];
    assign ch_sel  = bus_addr[0];

    sccreg_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (ctl_wr),
        .ctl_rd (ctl_rd),
        .wdata  (bus_wdata),
        .ptr    (ptr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sccreg_chan #(.EXT_EN_BIT(EXT_EN_BIT)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .ctl_wr       (ctl_wr && (ch_sel == 1'(c))),
            .data_wr      (data_wr && (ch_sel == 1'(c))),
            .ptr          (ptr),
            .wdata        (bus_wdata),
            .carrier      (carrier[c]),
            .data_byte    (ch_data[c]),
            .tc_lo        (ch_tclo[c]),
            .tc_hi        (ch_tchi[c]),
            .xstat        (ch_xstat[c]),
            .pend         (ch_pend[c]),
            .ext_en       (ch_ext_en[c]),
            .rx_len       (rx_char_bits[c*LEN_W +: LEN_W]),
            .tx_len       (tx_char_bits[c*LEN_W +: LEN_W]),
            .rx_crc_pulse (rx_crc_rst[c]),
            .tx_crc_pulse (tx_crc_rst[c]),
            .eom_pulse    (tx_eom_rst[c])
        );
    end

    assign irq_src = q.mst[MIE_BIT] && |(ch_pend & ch_ext_en);

    always_comb begin
        d = q;
        if (ctl_wr && ptr == REG_VEC) d.vec = bus_wdata;
        if (ctl_wr && ptr == REG_MST) d.mst = bus_wdata;
        d.irq = irq_src;
        d.chg = (irq_src != q.irq);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1]) begin
            bus_rdata = ch_data[ch_sel];
        end else begin
            case (ptr)
                REG_CMD:   bus_rdata = {4'b0, carrier[ch_sel], 3'b0};
                REG_IEN:   bus_rdata = 8'h01;
                REG_VEC:   bus_rdata = q.vec;
                REG_RXM:   bus_rdata = ch_sel ? 8'h00
                                      : {4'b0, ch_pend[0], 2'b0, ch_pend[1]};
                REG_TCLO:  bus_rdata = ch_tclo[ch_sel];
                REG_TCHI:  bus_rdata = ch_tchi[ch_sel];
                REG_XSTAT: bus_rdata = ch_xstat[ch_sel];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq     = q.irq;
    assign irq_chg = q.chg;

    // R1
    data_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[1]) |=> $stable(ptr));

    // R11
    irq_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_chg |-> (irq != $past(irq)));

    // R11
    irq_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.mst[MIE_BIT] |=> !irq);

    // R11
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_chg |-> $stable(irq));

endmodule

// File: tb/sim_sccreg_front.sv
module sim_sccreg_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] carrier = '0;
    logic       irq, irq_chg;
    logic [7:0] rx_char_bits, tx_char_bits;
    logic [1:0] rx_crc_rst, tx_crc_rst, tx_eom_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sccreg_front u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .carrier(carrier), .irq(irq), .irq_chg(irq_chg),
        .rx_char_bits(rx_char_bits), .tx_char_bits(tx_char_bits),
        .rx_crc_rst(rx_crc_rst), .tx_crc_rst(tx_crc_rst), .tx_eom_rst(tx_eom_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_car(input logic [1:0] a, input logic [7:0] v, input logic [1:0] car);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1; carrier = car;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rdc(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [3:0] exp_len(input logic [1:0] code);
        case (code)
            2'b00: return 4'd5;
            2'b01: return 4'd7;
            2'b10: return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    task automatic t_reset;
        idle(1);
        chk("R12 irq", irq, 0);
        chk("R12 irq_chg", irq_chg, 0);
        chk("R12 pulses", {rx_crc_rst, tx_crc_rst, tx_eom_rst}, 0);
        chk("R7 reset rx len", rx_char_bits, 8'h55);
        rdc(2'b00, 8'h00, "R12 ptr zero reads reg0");
        wr(2'b00, 8'h01);
        rdc(2'b00, 8'h01, "R8 reg1");
    endtask

    task automatic t_data;
        wr(2'b10, 8'h5A);
        wr(2'b11, 8'hC3);
        rdc(2'b10, 8'h5A, "R1 data A");
        rdc(2'b11, 8'hC3, "R1 data B");
        wr(2'b00, 8'h0C);
        wr(2'b11, 8'h77);
        wr(2'b00, 8'h34);
        wr(2'b00, 8'h0C);
        rdc(2'b00, 8'h34, "R1 ptr kept over data write");
        rdc(2'b11, 8'h77, "R1 data B rewritten");
    endtask

    task automatic t_ptr;
        wr(2'b00, 8'h0D);
        wr(2'b00, 8'h9A);
        wr(2'b00, 8'h0D);
        rdc(2'b00, 8'h9A, "R2 point high reg13");
        rdc(2'b00, 8'h00, "R3 back to 0 after read");
        wr(2'b00, 8'h01);
        wr(2'b00, 8'h00);
        rdc(2'b00, 8'h00, "R3 back to 0 after write");
        wr(2'b00, 8'h04);
        rdc(2'b00, 8'h00, "R2 no high bit without command");
    endtask

    task automatic t_perch;
        wr(2'b01, 8'h0C);
        wr(2'b01, 8'h66);
        wr(2'b01, 8'h0C);
        rdc(2'b01, 8'h66, "R5 tc lo B");
        wr(2'b00, 8'h0C);
        rdc(2'b00, 8'h34, "R5 tc lo A untouched");
    endtask

    task automatic t_shared;
        wr(2'b01, 8'h02);
        wr(2'b01, 8'hA5);
        wr(2'b00, 8'h02);
        rdc(2'b00, 8'hA5, "R4 vector via A");
        wr(2'b01, 8'h02);
        rdc(2'b01, 8'hA5, "R4 vector via B");
    endtask

    task automatic t_cmd;
        wr(2'b00, 8'h40);
        chk("R6 rx crc A", {rx_crc_rst, tx_crc_rst, tx_eom_rst}, 6'b01_00_00);
        idle(1);
        chk("R6 pulse one cycle", {rx_crc_rst, tx_crc_rst, tx_eom_rst}, 6'b0);
        wr(2'b01, 8'h80);
        chk("R6 tx crc B", {rx_crc_rst, tx_crc_rst, tx_eom_rst}, 6'b00_10_00);
        wr(2'b00, 8'hC0);
        chk("R6 eom A", {rx_crc_rst, tx_crc_rst, tx_eom_rst}, 6'b00_00_01);
    endtask

    task automatic t_len;
        for (int c = 0; c < 4; c++) begin
            wr(2'b00, 8'h03);
            wr(2'b00, {2'(c), 6'b0});
            chk("R7 rx len A", rx_char_bits[3:0], exp_len(2'(c)));
            wr(2'b01, 8'h05);
            wr(2'b01, {1'b0, 2'(c), 5'b0});
            chk("R7 tx len B", tx_char_bits[7:4], exp_len(2'(c)));
        end
    endtask

    task automatic t_status;
        @(negedge clk); carrier[0] = 1'b1;
        idle(1);
        rdc(2'b00, 8'h08, "R8 carrier in reg0");
        wr(2'b00, 8'h0F);
        rdc(2'b00, 8'h08, "R9 latched status");
        @(negedge clk); carrier[0] = 1'b0;
        idle(1);
        wr(2'b00, 8'h0F);
        rdc(2'b00, 8'h08, "R9 latch frozen while pending");
        wr(2'b00, 8'h03);
        rdc(2'b00, 8'h08, "R9 reg3 via A");
        wr(2'b01, 8'h03);
        rdc(2'b01, 8'h00, "R9 reg3 via B");
        chk("R11 no irq without enables", irq, 0);
    endtask

    task automatic t_irq;
        wr(2'b00, 8'h09);
        wr(2'b00, 8'h08);
        idle(1);
        chk("R11 mie alone", irq, 0);
        wr(2'b00, 8'h01);
        wr(2'b00, 8'h01);
        idle(1);
        chk("R11 irq rises", {irq, irq_chg}, 2'b11);
        idle(1);
        chk("R11 chg one cycle", {irq, irq_chg}, 2'b10);
        wr(2'b00, 8'h09);
        wr(2'b00, 8'h00);
        idle(1);
        chk("R11 mie off", {irq, irq_chg}, 2'b01);
        wr(2'b00, 8'h09);
        wr(2'b00, 8'h08);
        idle(1);
        chk("R11 mie back on", irq, 1);
    endtask

    task automatic t_clr;
        wr(2'b00, 8'h10);
        idle(1);
        chk("R10 clear drops irq", {irq, irq_chg}, 2'b01);
        wr(2'b00, 8'h0F);
        rdc(2'b00, 8'h00, "R10 latch cleared");
        wr(2'b00, 8'h03);
        rdc(2'b00, 8'h00, "R10 pending cleared");
        @(negedge clk); carrier[1] = 1'b1;
        idle(2);
        chk("R11 B pending but B disabled", irq, 0);
        wr(2'b01, 8'h10);
        @(negedge clk); carrier[1] = 1'b0;
        idle(1);
        wr_car(2'b01, 8'h10, 2'b10);
        wr(2'b01, 8'h0F);
        rdc(2'b01, 8'h08, "R10 same-cycle event wins latch");
        wr(2'b00, 8'h03);
        rdc(2'b00, 8'h01, "R10 same-cycle pending kept");
    endtask

    task automatic t_reset2;
        @(negedge clk); carrier = 2'b00; rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        chk("R12 irq after reset", irq, 0);
        chk("R12 len after reset", {tx_char_bits, rx_char_bits}, 16'h5555);
        rdc(2'b00, 8'h00, "R12 ptr after reset");
        wr(2'b00, 8'h03);
        rdc(2'b00, 8'h00, "R12 pending cleared");
        @(negedge clk); carrier[0] = 1'b1;
        idle(2);
        chk("R12 enables cleared", irq, 0);
        wr(2'b00, 8'h03);
        rdc(2'b00, 8'h08, "R12 pending sets again");
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_data();
        t_ptr();
        t_perch();
        t_shared();
        t_cmd();
        t_len();
        t_status();
        t_irq();
        t_clr();
        t_reset2();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule